// File: doc/BRIEF.md
# Implicit-Operand Multiply/Divide Unit

This unit carries out one multiply or divide at a time, on operands that are implied by the operand size rather than named. The caller presents the current contents of the accumulator (`acc_in`), the data register (`dat_in`), one explicit source operand (`src_in`), a size code, a signed/unsigned select and a multiply/divide select. It then pulses `start`. The unit reads only the bits that the size selects. It iterates one bit per cycle and returns the complete new accumulator and data-register values on `acc_out` and `dat_out`, together with a one-cycle `done`. Bits that the operation does not own keep their input values.

A multiply of two N-bit values produces a 2N-bit product. A divide takes a 2N-bit dividend and returns an N-bit quotient and an N-bit remainder. In the byte form both halves go to the low 16 bits of the accumulator. In the wider forms the result is split between the accumulator and the data register. After a multiply the unit reports a single flag value, used for both carry and overflow, and asserts `ovf_we` to show that the flag is to be updated. All other flags are left to the caller as undefined. A divide updates no flag. A divide whose divisor is zero, or whose quotient does not fit N bits, raises `fault` and suppresses the write.

Control is a four-state machine:
- `ST_IDLE` goes to `ST_MUL` when a multiply is accepted.
- `ST_IDLE` goes to `ST_DIV` when a divide is accepted and its quotient can fit.
- `ST_IDLE` goes straight to `ST_WRAP` when a divide is found to overflow before it starts (the early-fault transition).
- `ST_MUL` and `ST_DIV` go to `ST_WRAP` after their last step.
- `ST_WRAP` registers the results and returns to `ST_IDLE`.

Top module: `muldiv_unit`

## Requirements
- R1: `start` is accepted only while `busy` is low, and `busy` is high on the next cycle. `done` is a one-cycle pulse that is seen with `busy` low. A `start` raised while `busy` is high is ignored and produces no extra `done`. After reset `busy`, `done` and `fault` are low.
- R2: For an operation that does not fault early, `done` is seen N+1 cycles after the accepting edge, where N is the operand width. For a zero divisor, or a divide whose quotient magnitude is at least 2^N, `done` is seen one cycle after that edge.
- R3: `op_size` selects N: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits, and 3 behaves exactly like 2.
- R4: A byte multiply computes `acc_in[7:0]` times `src_in[7:0]` and writes the 16-bit product to `acc_out[15:0]`. `acc_out[31:16]` and all of `dat_out` keep their input values.
- R5: A 16-bit multiply writes the product's low half to `acc_out[15:0]` and its high half to `dat_out[15:0]`, keeping both upper halves. A 32-bit multiply writes the low half to `acc_out` and the high half to `dat_out`.
- R6: After a multiply, `ovf_we` is 1. For an unsigned multiply, `ovf_flag` is 1 exactly when the upper N bits of the product are not all zero. For a signed multiply, it is 1 exactly when the upper N bits are not the sign extension of the lower N bits.
- R7: A byte divide takes `acc_in[15:0]` as the dividend. It writes the quotient to `acc_out[7:0]` and the remainder to `acc_out[15:8]`, keeping `acc_out[31:16]` and `dat_out`.
- R8: A 16-bit divide takes `{dat_in[15:0], acc_in[15:0]}` as the dividend and writes the quotient to `acc_out[15:0]` and the remainder to `dat_out[15:0]`, keeping both upper halves. A 32-bit divide takes `{dat_in, acc_in}` and writes the quotient to `acc_out` and the remainder to `dat_out`.
- R9: A signed divide truncates the quotient toward zero, and the remainder carries the dividend's sign. A negative quotient of -2^(N-1) is valid.
- R10: A divide faults when the divisor is zero, or when the quotient does not fit N bits (unsigned: 2^N or more; signed: outside -2^(N-1)..2^(N-1)-1). On a fault, `fault` is 1, `wr_en` and `ovf_we` are 0, and `acc_out`/`dat_out` equal `acc_in`/`dat_in` as sampled at start.
- R11: A divide never asserts `ovf_we`. `wr_en` is 1 with `done` for every operation that does not fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation |
| op_div | input | 1 | 1 = divide, 0 = multiply |
| op_signed | input | 1 | 1 = two's-complement operands |
| op_size | input | 2 | Operand width code (0: 8, 1: 16, 2/3: 32) |
| acc_in | input | 32 | Current accumulator contents |
| dat_in | input | 32 | Current data-register contents |
| src_in | input | 32 | Explicit operand (low N bits used) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Divide fault, valid with `done` |
| wr_en | output | 1 | Write `acc_out`/`dat_out` back, valid with `done` |
| acc_out | output | 32 | New accumulator value |
| dat_out | output | 32 | New data-register value |
| ovf_we | output | 1 | Carry/overflow flags are to be updated |
| ovf_flag | output | 1 | New carry/overflow value |

## Verification
The assertions check the handshake on every cycle: acceptance raises `busy`, `done` is a lone pulse outside `busy`, a zero divisor reaches a faulting `done` on the early path, a fault never comes with a write or a flag update, and the iterative divider never runs with a zero divisor. Only the bench's scenarios can show the arithmetic. That covers the packing of each size into the two registers, the preserved upper bits, the signed and unsigned overflow flag, truncation toward zero with the remainder's sign, the quotient range limits, the exact latency, and a start raised while busy being ignored.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam int REG_W  = 32;
    localparam int PROD_W = 2 * REG_W;
    localparam int HALF_W = REG_W / 2;
    localparam int BYTE_W = REG_W / 4;
    localparam int WID_W  = $clog2(PROD_W) + 1;

    typedef logic [WID_W-1:0] wid_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DIV  = 2'd2,
        ST_WRAP = 2'd3
    } state_t;

    // Keep the low w bits of v, optionally sign-extending from bit w-1.
    function automatic logic [PROD_W-1:0] ext64(input logic [PROD_W-1:0] v,
                                                input wid_t w,
                                                input logic sg);
        logic [PROD_W-1:0] m;
        logic [PROD_W-1:0] top;
        logic [PROD_W-1:0] r;
        m   = (w >= wid_t'(PROD_W)) ? '1 : ((PROD_W'(1) << w) - PROD_W'(1));
        top = m & ~(m >> 1);
        r   = v & m;
        if (sg && (|(v & top)))
            r = r | ~m;
        return r;
    endfunction

endpackage

// File: rtl/muldiv_opnd.sv
module muldiv_opnd
    import muldiv_pkg::*;
(
    input  logic [1:0]        size_i,
    input  logic              div_i,
    input  logic              sgn_i,
    input  logic [REG_W-1:0]  acc_i,
    input  logic [REG_W-1:0]  dat_i,
    input  logic [REG_W-1:0]  src_i,
    output wid_t              nbits_o,
    output logic [PROD_W-1:0] a_mag_o,
    output logic              a_neg_o,
    output logic [PROD_W-1:0] b_mag_o,
    output logic              b_neg_o
);

    logic [PROD_W-1:0] a_raw, a_ext, b_ext;
    wid_t              a_w;

    always_comb begin
        unique case (size_i)
            2'd0:    nbits_o = wid_t'(BYTE_W);
            2'd1:    nbits_o = wid_t'(HALF_W);
            default: nbits_o = wid_t'(REG_W);
        endcase

        if (div_i) begin
            unique case (size_i)
                2'd0:    a_raw = {{(PROD_W-HALF_W){1'b0}}, acc_i[HALF_W-1:0]};
                2'd1:    a_raw = {{REG_W{1'b0}}, dat_i[HALF_W-1:0], acc_i[HALF_W-1:0]};
                default: a_raw = {dat_i, acc_i};
            endcase
            a_w = nbits_o << 1;
        end else begin
            a_raw = {{REG_W{1'b0}}, acc_i};
            a_w   = nbits_o;
        end

        a_ext   = ext64(a_raw, a_w, sgn_i);
        b_ext   = ext64({{REG_W{1'b0}}, src_i}, nbits_o, sgn_i);
        a_neg_o = sgn_i & a_ext[PROD_W-1];
        b_neg_o = sgn_i & b_ext[PROD_W-1];
        a_mag_o = a_neg_o ? (~a_ext + PROD_W'(1)) : a_ext;
        b_mag_o = b_neg_o ? (~b_ext + PROD_W'(1)) : b_ext;
    end

endmodule

// File: rtl/muldiv_iter.sv
module muldiv_iter
    import muldiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_mul,
    input  logic              load_div,
    input  logic              step_mul,
    input  logic              step_div,
    input  wid_t              nbits,
    input  logic [PROD_W-1:0] a_mag,
    input  logic [REG_W-1:0]  b_mag,
    output logic [REG_W-1:0]  hi_o,
    output logic [REG_W-1:0]  lo_o
);

    logic [REG_W-1:0] hi_q, lo_q, op_q;
    logic [REG_W:0]   sum, trial;
    logic [REG_W-1:0] diff;
    logic             ge;

    always_comb begin
        sum   = {1'b0, hi_q} + (lo_q[0] ? {1'b0, op_q} : '0);
        trial = {hi_q, lo_q[REG_W-1]};
        ge    = trial >= {1'b0, op_q};
        diff  = trial[REG_W-1:0] - op_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
            op_q <= '0;
        end else if (load_mul) begin
            hi_q <= '0;
            lo_q <= b_mag;
            op_q <= a_mag[REG_W-1:0];
        end else if (load_div) begin
            hi_q <= REG_W'(a_mag >> nbits);
            lo_q <= a_mag[REG_W-1:0] << (wid_t'(REG_W) - nbits);
            op_q <= b_mag;
        end else if (step_mul) begin
            hi_q <= sum[REG_W:1];
            lo_q <= {sum[0], lo_q[REG_W-1:1]};
        end else if (step_div) begin
            hi_q <= ge ? diff : trial[REG_W-1:0];
            lo_q <= {lo_q[REG_W-2:0], ge};
        end
    end

    assign hi_o = hi_q;
    assign lo_o = lo_q;

    // R10: the early-fault path keeps a zero divisor out of the divider
    p_div_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        step_div |-> (op_q != '0));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_div,
    input  logic              op_signed,
    input  logic [1:0]        op_size,
    input  logic [REG_W-1:0]  acc_in,
    input  logic [REG_W-1:0]  dat_in,
    input  logic [REG_W-1:0]  src_in,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic              wr_en,
    output logic [REG_W-1:0]  acc_out,
    output logic [REG_W-1:0]  dat_out,
    output logic              ovf_we,
    output logic              ovf_flag
);

    state_t            st_q, st_d;
    wid_t              nbits, nb_q, cnt_q;
    logic [PROD_W-1:0] a_mag, b_mag;
    logic              a_neg, b_neg;
    logic [REG_W-1:0]  hi, lo;
    logic              accept, pre_flt;
    logic              div_q, sgn_q, neg_q, rneg_q, pre_q;
    logic [1:0]        sz_q;
    logic [REG_W-1:0]  acc_q, dat_q;

    muldiv_opnd u_opnd (
        .size_i  (op_size),
        .div_i   (op_div),
        .sgn_i   (op_signed),
        .acc_i   (acc_in),
        .dat_i   (dat_in),
        .src_i   (src_in),
        .nbits_o (nbits),
        .a_mag_o (a_mag),
        .a_neg_o (a_neg),
        .b_mag_o (b_mag),
        .b_neg_o (b_neg)
    );

    assign accept  = start && (st_q == ST_IDLE);
    assign pre_flt = op_div && ((a_mag >> nbits) >= b_mag);

    muldiv_iter u_iter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_mul (accept && !op_div),
        .load_div (accept && op_div && !pre_flt),
        .step_mul (st_q == ST_MUL),
        .step_div (st_q == ST_DIV),
        .nbits    (nbits),
        .a_mag    (a_mag),
        .b_mag    (b_mag[REG_W-1:0]),
        .hi_o     (hi),
        .lo_o     (lo)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = !op_div ? ST_MUL : (pre_flt ? ST_WRAP : ST_DIV);
            ST_MUL:  if (cnt_q == wid_t'(1)) st_d = ST_WRAP;
            ST_DIV:  if (cnt_q == wid_t'(1)) st_d = ST_WRAP;
            ST_WRAP: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register and operand context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            nb_q   <= '0;
            sz_q   <= '0;
            div_q  <= 1'b0;
            sgn_q  <= 1'b0;
            neg_q  <= 1'b0;
            rneg_q <= 1'b0;
            pre_q  <= 1'b0;
            acc_q  <= '0;
            dat_q  <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                cnt_q  <= nbits;
                nb_q   <= nbits;
                sz_q   <= op_size;
                div_q  <= op_div;
                sgn_q  <= op_signed;
                neg_q  <= a_neg ^ b_neg;
                rneg_q <= a_neg;
                pre_q  <= pre_flt;
                acc_q  <= acc_in;
                dat_q  <= dat_in;
            end else if (st_q == ST_MUL || st_q == ST_DIV) begin
                cnt_q <= cnt_q - wid_t'(1);
            end
        end
    end

    // result shaping
    logic [PROD_W-1:0] prod_mag, prod;
    logic [PROD_W-1:0] qmask;
    logic [REG_W-1:0]  q_mag, q_val, r_val;
    logic [REG_W:0]    q_lim;
    logic              mul_ov, s_ovf, flt_now;
    logic [REG_W-1:0]  acc_w, dat_w;

    always_comb begin
        prod_mag = {hi, lo} >> (wid_t'(REG_W) - nb_q);
        prod     = neg_q ? (~prod_mag + PROD_W'(1)) : prod_mag;
        mul_ov   = sgn_q ? (prod != ext64(prod, nb_q, 1'b1)) : ((prod >> nb_q) != '0);
        qmask    = ext64('1, nb_q, 1'b0);
        q_mag    = lo & qmask[REG_W-1:0];
        q_val    = neg_q ? (~q_mag + REG_W'(1)) : q_mag;
        r_val    = rneg_q ? (~hi + REG_W'(1)) : hi;
        q_lim    = (REG_W+1)'(1) << (nb_q - wid_t'(1));
        s_ovf    = neg_q ? ({1'b0, q_mag} > q_lim) : ({1'b0, q_mag} >= q_lim);
        flt_now  = div_q && (pre_q || (sgn_q && s_ovf));

        acc_w = acc_q;
        dat_w = dat_q;
        unique case (sz_q)
            2'd0: begin
                if (div_q) acc_w = {acc_q[REG_W-1:HALF_W], r_val[BYTE_W-1:0], q_val[BYTE_W-1:0]};
                else       acc_w = {acc_q[REG_W-1:HALF_W], prod[HALF_W-1:0]};
            end
            2'd1: begin
                if (div_q) begin
                    acc_w = {acc_q[REG_W-1:HALF_W], q_val[HALF_W-1:0]};
                    dat_w = {dat_q[REG_W-1:HALF_W], r_val[HALF_W-1:0]};
                end else begin
                    acc_w = {acc_q[REG_W-1:HALF_W], prod[HALF_W-1:0]};
                    dat_w = {dat_q[REG_W-1:HALF_W], prod[REG_W-1:HALF_W]};
                end
            end
            default: begin
                if (div_q) begin
                    acc_w = q_val;
                    dat_w = r_val;
                end else begin
                    acc_w = prod[REG_W-1:0];
                    dat_w = prod[PROD_W-1:REG_W];
                end
            end
        endcase
        if (flt_now) begin
            acc_w = acc_q;
            dat_w = dat_q;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            fault    <= 1'b0;
            wr_en    <= 1'b0;
            ovf_we   <= 1'b0;
            ovf_flag <= 1'b0;
            acc_out  <= '0;
            dat_out  <= '0;
        end else if (st_q == ST_WRAP) begin
            done     <= 1'b1;
            fault    <= flt_now;
            wr_en    <= !flt_now;
            ovf_we   <= !div_q;
            ovf_flag <= !div_q && mul_ov;
            acc_out  <= acc_w;
            dat_out  <= dat_w;
        end else begin
            done   <= 1'b0;
            wr_en  <= 1'b0;
            ovf_we <= 1'b0;
        end
    end

    assign busy = (st_q != ST_IDLE);

    // R1: acceptance makes the unit busy
    p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R1: done comes outside busy and lasts one cycle
    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a zero divisor takes the early path to a faulting done
    p_zero_div_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op_div && ((src_in & qmask_in(op_size)) == '0))
            |-> ##2 (done && fault));

    // R10: a fault never writes back or touches flags
    p_fault_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (!wr_en && !ovf_we));

    // R11: a flag update only comes with a write
    p_flag_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_we |-> (done && wr_en));

    function automatic logic [REG_W-1:0] qmask_in(input logic [1:0] s);
        unique case (s)
            2'd0:    return REG_W'((1 << BYTE_W) - 1);
            2'd1:    return REG_W'((1 << HALF_W) - 1);
            default: return '1;
        endcase
    endfunction

endmodule

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_div = 1'b0;
    logic        op_signed = 1'b0;
    logic [1:0]  op_size = 2'd0;
    logic [31:0] acc_in = '0, dat_in = '0, src_in = '0;
    logic        busy, done, fault, wr_en, ovf_we, ovf_flag;
    logic [31:0] acc_out, dat_out;

    always #2 clk = ~clk;

    muldiv_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
        .op_signed(op_signed), .op_size(op_size), .acc_in(acc_in),
        .dat_in(dat_in), .src_in(src_in), .busy(busy), .done(done),
        .fault(fault), .wr_en(wr_en), .acc_out(acc_out), .dat_out(dat_out),
        .ovf_we(ovf_we), .ovf_flag(ovf_flag)
    );

    typedef struct {
        logic [31:0] acc;
        logic [31:0] dat;
        logic        flt;
        logic        wr;
        logic        fwe;
        logic        fov;
        int          lat;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   reported = 0;

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    function automatic logic [63:0] sx(input logic [63:0] v, input int w, input logic sg);
        logic [63:0] m;
        logic [63:0] r;
        if (w >= 64) return v;
        m = (64'd1 << w) - 64'd1;
        r = v & m;
        if (sg && v[w-1]) r = r | ~m;
        return r;
    endfunction

    function automatic exp_t model(input logic dv, input logic sg, input logic [1:0] sz,
                                   input logic [31:0] a, input logic [31:0] d,
                                   input logic [31:0] s, input string tag);
        exp_t e;
        int n;
        logic [63:0] x, y, p, raw, dm, bm, qm, rm, q, r;
        logic dn, bn, qn, bad;
        n = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        e.tag = tag;
        e.acc = a;
        e.dat = d;
        e.lat = n + 2;
        if (!dv) begin
            x = sx({32'b0, a}, n, sg);
            y = sx({32'b0, s}, n, sg);
            p = x * y;
            e.flt = 0; e.wr = 1; e.fwe = 1;
            e.fov = sg ? (p != sx(p, n, 1'b1)) : ((p >> n) != 0);
            if (n == 8)       e.acc = {a[31:16], p[15:0]};
            else if (n == 16) begin e.acc = {a[31:16], p[15:0]}; e.dat = {d[31:16], p[31:16]}; end
            else              begin e.acc = p[31:0]; e.dat = p[63:32]; end
        end else begin
            if (n == 8)       raw = {48'b0, a[15:0]};
            else if (n == 16) raw = {32'b0, d[15:0], a[15:0]};
            else              raw = {d, a};
            x  = sx(raw, 2 * n, sg);
            y  = sx({32'b0, s}, n, sg);
            dn = sg && x[63];
            bn = sg && y[63];
            dm = dn ? -x : x;
            bm = bn ? -y : y;
            qn = dn ^ bn;
            e.fwe = 0; e.fov = 0;
            if (bm == 0) begin
                bad = 1; e.lat = 2; qm = 0; rm = 0;
            end else begin
                qm = dm / bm;
                rm = dm % bm;
                if ((qm >> n) != 0) e.lat = 2;
                if (sg) bad = qn ? (qm > (64'd1 << (n - 1))) : (qm >= (64'd1 << (n - 1)));
                else    bad = (qm >> n) != 0;
            end
            q = qn ? -qm : qm;
            r = dn ? -rm : rm;
            e.flt = bad;
            e.wr  = !bad;
            if (!bad) begin
                if (n == 8)       e.acc = {a[31:16], r[7:0], q[7:0]};
                else if (n == 16) begin e.acc = {a[31:16], q[15:0]}; e.dat = {d[31:16], r[15:0]}; end
                else              begin e.acc = q[31:0]; e.dat = r[31:0]; end
            end
        end
        return e;
    endfunction

    // monitor: pops the scoreboard on every done
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R1 unexpected done: actual 1 expected 0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, "acc_out", {32'b0, acc_out}, {32'b0, e.acc});
                check(e.tag, "dat_out", {32'b0, dat_out}, {32'b0, e.dat});
                check(e.tag, "fault",   {63'b0, fault},   {63'b0, e.flt});
                check(e.tag, "wr_en",   {63'b0, wr_en},   {63'b0, e.wr});
                check(e.tag, "ovf_we",  {63'b0, ovf_we},  {63'b0, e.fwe});
                if (e.fwe) check(e.tag, "ovf_flag", {63'b0, ovf_flag}, {63'b0, e.fov});
                check("R1", "busy at done", {63'b0, busy}, 64'd0);
            end
        end
    end

    // driver: pushes the expectation, then issues the operation
    task automatic run_op(input logic dv, input logic sg, input logic [1:0] sz,
                          input logic [31:0] a, input logic [31:0] d, input logic [31:0] s,
                          input string tag, input bit stray = 0);
        exp_t e;
        int cyc;
        e = model(dv, sg, sz, a, d, s, tag);
        exp_q.push_back(e);
        @(negedge clk);
        op_div = dv; op_signed = sg; op_size = sz;
        acc_in = a; dat_in = d; src_in = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 100) begin
            if (stray && cyc == 3) begin
                start = 1'b1;
                op_div = 1'b1;
                src_in = 32'd0;
                acc_in = 32'h5555_5555;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check({"R2 ", tag}, "latency", 64'(cyc), 64'(e.lat));
    endtask

    initial begin
        #(200000 * 4);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset busy",  {63'b0, busy},  64'd0);
        check("R1", "reset done",  {63'b0, done},  64'd0);
        check("R1", "reset fault", {63'b0, fault}, 64'd0);

        // R4: byte multiply, R6 unsigned flag
        run_op(0, 0, 2'd0, 32'hABCD_0003, 32'h1111_2222, 32'h0000_0005, "R4");
        run_op(0, 0, 2'd0, 32'h1234_56FF, 32'h0, 32'h0000_00FF, "R6");
        // R6: signed byte flag
        run_op(0, 1, 2'd0, 32'h0000_00FF, 32'h0, 32'h0000_00FF, "R6");
        run_op(0, 1, 2'd0, 32'h0000_0080, 32'h0, 32'h0000_00FF, "R6");
        run_op(0, 1, 2'd0, 32'h0000_00F0, 32'h0, 32'h0000_0008, "R6");
        // R5: word and dword multiply, R3 size 3
        run_op(0, 0, 2'd1, 32'hDEAD_1234, 32'hBEEF_9999, 32'h0000_5678, "R5");
        run_op(0, 1, 2'd1, 32'h0000_FFFE, 32'hAAAA_0000, 32'h0000_0003, "R5");
        run_op(0, 0, 2'd2, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, "R5");
        run_op(0, 1, 2'd2, 32'h8000_0000, 32'h0, 32'h8000_0000, "R6");
        run_op(0, 1, 2'd3, 32'hFFFF_FFF9, 32'h0, 32'h0000_0006, "R3");
        // R7: byte divide
        run_op(1, 0, 2'd0, 32'h7777_0064, 32'h3333_3333, 32'h0000_0007, "R7");
        run_op(1, 1, 2'd0, 32'h0000_FFF9, 32'h0, 32'h0000_0002, "R9");
        run_op(1, 1, 2'd0, 32'h0000_0007, 32'h0, 32'h0000_00FE, "R9");
        run_op(1, 1, 2'd0, 32'h0000_FF00, 32'h0, 32'h0000_0002, "R9");
        // R8: word and dword divide, R11 no flag update
        run_op(1, 0, 2'd1, 32'hCAFE_0010, 32'h1234_0001, 32'h0000_0100, "R8");
        run_op(1, 1, 2'd1, 32'h0000_0000, 32'h0000_FFFF, 32'h0000_0003, "R11");
        run_op(1, 0, 2'd2, 32'h8765_4321, 32'h0000_0012, 32'h0001_0000, "R8");
        run_op(1, 1, 2'd3, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 32'h0000_0003, "R3");
        // R10: zero divisor, unsigned overflow, signed overflow
        run_op(1, 0, 2'd0, 32'h0000_1234, 32'h0, 32'hFFFF_FF00, "R10");
        run_op(1, 0, 2'd0, 32'h0000_1000, 32'h0, 32'h0000_0001, "R10");
        run_op(1, 1, 2'd0, 32'h0000_FF80, 32'h0, 32'h0000_00FF, "R10");
        run_op(1, 1, 2'd1, 32'h0000_8000, 32'h0000_0000, 32'h0000_0001, "R10");
        run_op(1, 1, 2'd2, 32'h0000_0000, 32'h8000_0000, 32'hFFFF_FFFF, "R10");
        run_op(1, 0, 2'd2, 32'h0, 32'h5, 32'h0, "R10");
        // R1: start while busy is ignored
        run_op(0, 0, 2'd2, 32'h0001_0001, 32'h0, 32'h0002_0003, "R1", 1);

        repeat (40) @(negedge clk);
        check("R1", "queue drained", 64'(exp_q.size()), 64'd0);
        summary();
        $finish;
    end

endmodule